// File: doc/BRIEF.md
# Flash Storage Array Emulator

This block is a synthesizable stand-in for a small flash storage array, for use where a design under development needs a non-volatile store that follows flash rules. The store is split into blocks, each block into pages, each page into words, and it is held in on-chip registers. Three operations reach it through one command port: fetch a single word, program a single word or a whole page, and erase a whole block.

Flash rules are applied to every operation. An erase sets every bit of the addressed block back to one. A program can only clear bits, so the stored word becomes the old word ANDed with the new data. A page may be programmed as a page only once between erases; a second attempt is refused, leaves the data alone, and pulses an error. A word program that would need a bit to go from zero to one pulses a separate flag and still stores the AND result.

Programs and erases hold the command port not-ready for a parameterised number of cycles and pulse a completion strobe when they finish. Reads complete in one cycle and do not make the port busy.

Top module: `flash_array_emu`

## Requirements
- R1: After reset every word reads all ones, `cmd_ready` is high and `op_done`, `rd_valid`, `rewrite_viol` and `page_reprog_err` are low.
- R2: A read (`cmd_op` 2'b00) accepted at a clock edge drives `rd_valid` high for exactly the next cycle, with `rd_data` equal to the word at `cmd_addr` before that edge; a read leaves `cmd_ready` high.
- R3: A word program (`cmd_op` 2'b01) stores the old word ANDed with `cmd_wdata[DATA_W-1:0]` at `cmd_addr`.
- R4: A word program whose zero bits include every zero bit already stored raises no flag and leaves the word equal to the new data.
- R5: A word program whose data has a one where the stored word has a zero pulses `rewrite_viol` for the cycle after acceptance, and the AND result is still stored.
- R6: A page program (`cmd_op` 2'b10) to a page not programmed since its block was erased ANDs word w of the page with `cmd_wdata[w*DATA_W +: DATA_W]`; the word bits of `cmd_addr` (its lowest log2(WORDS_PER_PAGE) bits) are ignored.
- R7: A second page program to the same page before its block is erased pulses `page_reprog_err` for the cycle after acceptance and changes no data.
- R8: An erase (`cmd_op` 2'b11) sets every word of the block named by the top address bits to all ones, makes every page of that block programmable again, and leaves other blocks unchanged.
- R9: After a program is accepted `cmd_ready` is low for PROG_CYCLES cycles (ERASE_CYCLES for an erase), then returns high in the same cycle that `op_done` pulses for one cycle.
- R10: A command presented while `cmd_ready` is low is ignored: no data, flag or output changes because of it.
- R11: The address is split, from most to least significant, into block, page within block, and word within page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 read, 01 word program, 10 page program, 11 block erase |
| cmd_addr | input | ADDR_W (6) | Word address: block, page, word |
| cmd_wdata | input | WORDS_PER_PAGE*DATA_W (64) | Program data; word mode uses the low DATA_W bits |
| cmd_ready | output | 1 | High when a command can be accepted |
| op_done | output | 1 | One-cycle pulse when a program or erase finishes |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W (16) | Read data |
| rewrite_viol | output | 1 | Word program needed a zero-to-one change |
| page_reprog_err | output | 1 | Page program refused, page already programmed |

## Verification
The bench drives word rewrites whose zero sets are supersets and ones that would raise bits, so a design that overwrote instead of ANDing, or flagged the legal case, returns the wrong word or a stray flag pulse. It programs a page twice and then erases and programs it again, catching a design that lets the second pass through or never clears the per-page mark. It holds commands on the port during busy windows and issues back-to-back random traffic, so a busy counter that is off by one or that accepts commands while busy shows up as a ready, done or data mismatch against the reference model.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [1:0] {
    OP_READ      = 2'b00,
    OP_PROG_WORD = 2'b01,
    OP_PROG_PAGE = 2'b10,
    OP_ERASE     = 2'b11
  } flash_op_e;
endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYCLES  = 3,
  parameter int ERASE_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_erase,
  output logic ready,
  output logic done
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] remain_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (remain_q == CW'(1));
      if (launch)
        remain_q <= launch_erase ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
      else if (remain_q != '0)
        remain_q <= remain_q - CW'(1);
    end
  end

  assign ready = (remain_q == '0);
  assign done  = done_q;

  assert_launch_goes_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !ready);
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && $past(!ready)));
endmodule

// File: rtl/flash_page_flags.sv
module flash_page_flags #(
  parameter int BLOCKS          = 4,
  parameter int PAGES_PER_BLOCK = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       set_en,
  input  logic [$clog2(BLOCKS*PAGES_PER_BLOCK)-1:0]  page_idx,
  input  logic                                       clr_en,
  input  logic [$clog2(BLOCKS)-1:0]                  clr_blk,
  output logic                                       page_used
);
  localparam int PAGE_TOTAL = BLOCKS * PAGES_PER_BLOCK;
  localparam int BLK_AW     = $clog2(BLOCKS);

  logic [PAGE_TOTAL-1:0] used_q;
  logic [BLK_AW-1:0]     clr_blk_q;

  for (genvar g = 0; g < PAGE_TOTAL; g++) begin : g_page
    localparam int OWNER = g / PAGES_PER_BLOCK;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        used_q[g] <= 1'b0;
      else if (clr_en && (clr_blk == BLK_AW'(OWNER)))
        used_q[g] <= 1'b0;
      else if (set_en && (page_idx == $bits(page_idx)'(g)))
        used_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_blk_q <= '0;
    else        clr_blk_q <= clr_blk;
  end

  assign page_used = used_q[page_idx];

  assert_erase_frees_pages_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (used_q[clr_blk_q*PAGES_PER_BLOCK +: PAGES_PER_BLOCK] == '0));
  assert_program_marks_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> used_q[$past(page_idx)]);
endmodule

// File: rtl/flash_word_store.sv
module flash_word_store #(
  parameter int BLOCKS          = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int WORDS_PER_PAGE  = 4,
  parameter int DATA_W          = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(BLOCKS*PAGES_PER_BLOCK*WORDS_PER_PAGE)-1:0] addr,
  input  logic [WORDS_PER_PAGE*DATA_W-1:0]    wdata,
  input  logic                                rd_en,
  input  logic                                wr_word_en,
  input  logic                                wr_page_en,
  input  logic                                erase_en,
  output logic                                rd_valid,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                raise_viol
);
  localparam int WORDS_PER_BLOCK = PAGES_PER_BLOCK * WORDS_PER_PAGE;
  localparam int WORD_TOTAL      = BLOCKS * WORDS_PER_BLOCK;
  localparam int ADDR_W          = $clog2(WORD_TOTAL);
  localparam int WRD_AW          = $clog2(WORDS_PER_PAGE);
  localparam int PG_AW           = $clog2(PAGES_PER_BLOCK);

  function automatic logic [DATA_W-1:0] merge_program(input logic [DATA_W-1:0] cur,
                                                      input logic [DATA_W-1:0] nxt);
    return cur & nxt;
  endfunction

  function automatic logic needs_raise(input logic [DATA_W-1:0] cur,
                                       input logic [DATA_W-1:0] nxt);
    return |(nxt & ~cur);
  endfunction

  logic [DATA_W-1:0] mem [WORD_TOTAL];
  logic [DATA_W-1:0] cur_word;
  logic [ADDR_W-WRD_AW-1:0]       page_sel;
  logic [ADDR_W-WRD_AW-PG_AW-1:0] blk_sel;

  assign cur_word = mem[addr];
  assign page_sel = addr[ADDR_W-1:WRD_AW];
  assign blk_sel  = addr[ADDR_W-1:WRD_AW+PG_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORD_TOTAL; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORD_TOTAL; i++) begin
        if (erase_en && ((i / WORDS_PER_BLOCK) == int'(blk_sel)))
          mem[i] <= '1;
        else if (wr_page_en && ((i / WORDS_PER_PAGE) == int'(page_sel)))
          mem[i] <= merge_program(mem[i], wdata[(i % WORDS_PER_PAGE)*DATA_W +: DATA_W]);
        else if (wr_word_en && (i == int'(addr)))
          mem[i] <= merge_program(mem[i], wdata[DATA_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      raise_viol <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      raise_viol <= wr_word_en && needs_raise(cur_word, wdata[DATA_W-1:0]);
      if (rd_en) rd_data <= cur_word;
    end
  end

  assert_word_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_en && !erase_en && !wr_page_en) |=>
      (mem[$past(addr)] == ($past(cur_word) & $past(wdata[DATA_W-1:0]))));
  assert_erase_sets_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (mem[$past(addr)] == '1));
  assert_viol_from_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raise_viol |-> $past(wr_word_en));
  assert_read_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_en) && (rd_data == $past(cur_word))));
endmodule

// File: rtl/flash_array_emu.sv
module flash_array_emu
  import flash_emu_pkg::*;
#(
  parameter int BLOCKS          = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int WORDS_PER_PAGE  = 4,
  parameter int DATA_W          = 16,
  parameter int PROG_CYCLES     = 3,
  parameter int ERASE_CYCLES    = 6,
  localparam int ADDR_W         = $clog2(BLOCKS*PAGES_PER_BLOCK*WORDS_PER_PAGE),
  localparam int PAGE_W         = WORDS_PER_PAGE*DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              op_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rewrite_viol,
  output logic              page_reprog_err
);
  localparam int WRD_AW = $clog2(WORDS_PER_PAGE);
  localparam int PG_AW  = $clog2(PAGES_PER_BLOCK);

  flash_op_e op;
  logic accept, launch, page_used;
  logic rd_en, wr_word_en, wr_page_en, erase_en, refuse_page;
  logic page_err_q;

  assign op          = flash_op_e'(cmd_op);
  assign accept      = cmd_valid && cmd_ready;
  assign rd_en       = accept && (op == OP_READ);
  assign wr_word_en  = accept && (op == OP_PROG_WORD);
  assign refuse_page = accept && (op == OP_PROG_PAGE) && page_used;
  assign wr_page_en  = accept && (op == OP_PROG_PAGE) && !page_used;
  assign erase_en    = accept && (op == OP_ERASE);
  assign launch      = accept && (op != OP_READ);

  flash_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_erase(erase_en),
    .ready(cmd_ready), .done(op_done)
  );

  flash_page_flags #(.BLOCKS(BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(wr_page_en),
    .page_idx(cmd_addr[ADDR_W-1:WRD_AW]), .clr_en(erase_en),
    .clr_blk(cmd_addr[ADDR_W-1:WRD_AW+PG_AW]), .page_used(page_used)
  );

  flash_word_store #(.BLOCKS(BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
                     .WORDS_PER_PAGE(WORDS_PER_PAGE), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(cmd_addr), .wdata(cmd_wdata),
    .rd_en(rd_en), .wr_word_en(wr_word_en), .wr_page_en(wr_page_en), .erase_en(erase_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .raise_viol(rewrite_viol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_err_q <= 1'b0;
    else        page_err_q <= refuse_page;
  end
  assign page_reprog_err = page_err_q;

  assert_refused_page_was_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_reprog_err |-> $past(page_used && cmd_valid && (cmd_op == 2'b10)));
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready) |=> !rd_valid && !rewrite_viol && !page_reprog_err);
  assert_read_keeps_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en) |=> cmd_ready);
  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, rewrite_viol, page_reprog_err}));
endmodule

// File: tb/tb_flash_array_emu.sv
module tb_flash_array_emu;
  localparam int PROG  = 3;
  localparam int ERASE = 6;
  localparam int NW    = 64;
  localparam int NP    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [5:0]  cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic        cmd_ready, op_done, rd_valid, rewrite_viol, page_reprog_err;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  flash_array_emu dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .op_done(op_done), .rd_valid(rd_valid), .rd_data(rd_data),
    .rewrite_viol(rewrite_viol), .page_reprog_err(page_reprog_err)
  );

  int vectors = 0;
  int misses  = 0;
  string tag = "R1";

  // Behavioural reference
  logic [15:0] m_mem [NW];
  bit          m_used [NP];
  int          m_busy;
  bit          e_done, e_rv, e_viol, e_perr;
  logic [15:0] e_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) m_mem[i] = 16'hFFFF;
      for (int i = 0; i < NP; i++) m_used[i] = 0;
      m_busy = 0; e_done = 0; e_rv = 0; e_viol = 0; e_perr = 0; e_rd = '0;
    end else begin
      e_done = (m_busy == 1); e_rv = 0; e_viol = 0; e_perr = 0;
      if (m_busy == 0 && cmd_valid) begin
        int a, pg, bk;
        a = int'(cmd_addr); pg = a / 4; bk = a / 16;
        case (cmd_op)
          2'b00: begin e_rv = 1; e_rd = m_mem[a]; end
          2'b01: begin
            e_viol = ((cmd_wdata[15:0] & ~m_mem[a]) != 16'h0);
            m_mem[a] = m_mem[a] & cmd_wdata[15:0];
            m_busy = PROG;
          end
          2'b10: begin
            if (m_used[pg]) e_perr = 1;
            else begin
              for (int w = 0; w < 4; w++) m_mem[pg*4+w] = m_mem[pg*4+w] & cmd_wdata[w*16 +: 16];
              m_used[pg] = 1;
            end
            m_busy = PROG;
          end
          default: begin
            for (int w = 0; w < 16; w++) m_mem[bk*16+w] = 16'hFFFF;
            for (int p = 0; p < 4; p++) m_used[bk*4+p] = 0;
            m_busy = ERASE;
          end
        endcase
      end else if (m_busy > 0) begin
        m_busy = m_busy - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", req, tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "cmd_ready", {15'd0, cmd_ready}, {15'd0, m_busy == 0});
      chk("R9", "op_done", {15'd0, op_done}, {15'd0, e_done});
      chk("R2", "rd_valid", {15'd0, rd_valid}, {15'd0, e_rv});
      chk("R5", "rewrite_viol", {15'd0, rewrite_viol}, {15'd0, e_viol});
      chk("R7", "page_reprog_err", {15'd0, page_reprog_err}, {15'd0, e_perr});
      if (e_rv) chk("R2", "rd_data", rd_data, e_rd);
    end
  end

  task automatic send(input logic [1:0] op, input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] known, input string req);
    send(2'b00, a, '0);
    // rd_valid and rd_data are visible at this negedge (one register)
    chk(req, "directed read", rd_data, known);
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1", "ready after reset", {15'd0, cmd_ready}, 16'd1);
    rd(6'd0, 16'hFFFF, "R1");
    rd(6'd63, 16'hFFFF, "R1");

    tag = "R3 R11";
    send(2'b01, 6'd5, 64'h0000_0000_0000_F0F0);
    rd(6'd5, 16'hF0F0, "R3");
    tag = "R4";
    send(2'b01, 6'd5, 64'h0000_0000_0000_00F0);
    rd(6'd5, 16'h00F0, "R4");
    tag = "R5";
    send(2'b01, 6'd5, 64'h0000_0000_0000_0F0F);
    rd(6'd5, 16'h0000, "R5");

    tag = "R6 R11";  // block 1, page 2, word bits 3 ignored
    send(2'b10, 6'b01_10_11, 64'h1234_5678_9ABC_DEF0);
    rd(6'b01_10_00, 16'hDEF0, "R6");
    rd(6'b01_10_11, 16'h1234, "R6");
    tag = "R7";
    send(2'b10, 6'b01_10_00, 64'h0);
    rd(6'b01_10_01, 16'h9ABC, "R7");

    tag = "R10";  // hold a program on the port while busy
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 6'd40; cmd_wdata = 64'h0;
    @(negedge clk);
    cmd_addr = 6'd41;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    rd(6'd40, 16'h0000, "R10");
    rd(6'd41, 16'hFFFF, "R10");

    tag = "R8";
    send(2'b11, 6'b01_00_00, 64'h0);
    rd(6'b01_10_00, 16'hFFFF, "R8");
    rd(6'd5, 16'h0000, "R8");
    send(2'b10, 6'b01_10_00, 64'hFFFF_FFFF_FFFF_0001);
    rd(6'b01_10_00, 16'h0001, "R8");

    tag = "R9 random";
    lf = 32'hACE1_2468;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cmd_valid = lf[12];
      cmd_op    = (lf[1:0] == 2'b11 && lf[5:2] != 4'h0) ? 2'b00 : lf[1:0];
      cmd_addr  = lf[11:6];
      cmd_wdata = {lf, ~lf} | {lf[15:0], lf[31:16], lf};
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    for (int i = 0; i < 64; i++) rd(i[5:0], m_mem[i], "R2");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule